// File: doc/BRIEF.md
# Dual-Processor Interrupt Flag Controller

This block collects interrupt events from peripherals and presents them to two processors. Each processor owns three registers: a one-bit master switch, a mask that selects which sources may raise a flag, and a flag register that records sources that have fired. A peripheral reports an event as a single-cycle strobe that carries the target processor index and a source number. The flag is recorded whenever the mask allows it, even while that processor's master switch is off. Software clears flags by writing ones to them.

For each processor the block drives a level interrupt line and a wake indication for use while the processor is halted. The interrupt line is gated by the master switch. The wake rule differs between the two processors. Processor 0 wakes only when its master switch is on. Processor 1 wakes on any flagged and unmasked source, whatever its master switch holds. A parameter selects this rule per processor.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset every master, mask and flag register reads as zero, and all interrupt and wake outputs are low.
- R2: An event strobe for processor c and source s sets flag bit s of c only when mask bit s of c is 1. Otherwise that flag register is left unchanged.
- R3: A flag bit is recorded while the master switch of that processor is 0.
- R4: A write to a flag register clears each flag bit whose written bit is 1 and leaves the other flag bits unchanged.
- R5: When an event and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R6: Only bit 0 of a master register is stored. Bits 31..1 always read as 0.
- R7: The interrupt output of processor c is high exactly when its master bit is 1 and (flags AND mask) of c is nonzero. It changes in the cycle after the register update that causes the change.
- R8: The wake output of processor 0 is high exactly when its master bit is 1 and (flags AND mask) is nonzero.
- R9: The wake output of processor 1 is high exactly when its (flags AND mask) is nonzero, whatever its master bit holds.
- R10: Register map. Address bit 8 selects the processor. Byte offset 0x08 is the master register, 0x10 is the mask and 0x14 is the flags. Any other offset reads as 0 and ignores writes. A write to one processor's registers never changes the other processor's registers.
- R11: Writing a mask register never changes the flags. A flag whose mask bit is cleared stays set but no longer drives the interrupt or wake outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address; bit 8 selects the processor |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_cpu | input | 1 | Target processor of the event |
| ev_src | input | 5 | Source number of the event |
| irq | output | 2 | Level interrupt line per processor |
| wake | output | 2 | Halt-wake indication per processor |

## Verification
A wrong flag or mask bit shows on reg_rdata as soon as the register is read back. It also shows on irq or wake in the cycle after the event or write that caused it, because both outputs are combinational from the registers. A master bit that is lost or stuck shows on the interrupt line at once, and on wake for processor 0 only. A processor 1 wake that obeys the master switch shows up when the master switch is off and a flag is unmasked. Sweeping every source on both processors under a sparse mask exposes swapped bits, cross-processor leakage and mask bypass within one cycle of the offending strobe.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;

   // byte offsets inside one processor bank
   localparam int OFS_MASTER = 8'h08;
   localparam int OFS_MASK   = 8'h10;
   localparam int OFS_FLAGS  = 8'h14;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_MASTER = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_FLAGS  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/dual_irq_decode.sv
module dual_irq_decode
   import dual_irq_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int BANK_LSB    = 8,
   parameter int NUM_CPUS    = 2,
   parameter int CPU_W       = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [CPU_W-1:0]  cpu,
   output logic              hit
);
   localparam int BANK_W = ADDR_W - BANK_LSB;

   logic [BANK_W-1:0]   bank;
   logic [BANK_LSB-1:0] ofs;
   logic                bank_ok;

   assign bank    = addr[ADDR_W-1:BANK_LSB];
   assign ofs     = addr[BANK_LSB-1:0];
   assign bank_ok = (int'(bank) < NUM_CPUS);
   assign cpu     = CPU_W'(bank);

   always_comb begin
      sel = SEL_NONE;
      if (ofs == BANK_LSB'(OFS_MASTER))     sel = SEL_MASTER;
      else if (ofs == BANK_LSB'(OFS_MASK))  sel = SEL_MASK;
      else if (ofs == BANK_LSB'(OFS_FLAGS)) sel = SEL_FLAGS;
   end

   assign hit = bank_ok && (sel != SEL_NONE);

endmodule

// File: rtl/dual_irq_bank.sv
module dual_irq_bank #(
   parameter int NUM_SRC = 32,
   parameter int SRC_W   = 5,
   parameter int CPU_W   = 1,
   parameter int CPU_ID  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_master,
   input  logic               wr_mask,
   input  logic               wr_flags,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic               ev_valid,
   input  logic [CPU_W-1:0]   ev_cpu,
   input  logic [SRC_W-1:0]   ev_src,
   output logic               master_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] flags_q
);
   localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

   logic               ev_hit;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;

   assign ev_hit  = ev_valid && (ev_cpu == CPU_W'(CPU_ID));
   assign set_vec = ev_hit ? ((ONE << ev_src) & mask_q) : '0;
   assign clr_vec = wr_flags ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         mask_q   <= '0;
         flags_q  <= '0;
      end else begin
         if (wr_master) master_q <= wdata[0];
         if (wr_mask)   mask_q   <= wdata;
         flags_q <= (flags_q & ~clr_vec) | set_vec;
      end
   end

   // R2: a newly set flag bit came from an event on a masked-in source
   a_r2_set_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~$past(flags_q)) != '0) |->
         ($past(ev_hit) && (((flags_q & ~$past(flags_q)) & ~$past(mask_q)) == '0)));

   // R4: a clearing write without an event leaves no written bit set
   a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_flags && !ev_hit) |-> ((flags_q & $past(wdata)) == '0));

   // R3 / R5: an accepted event always lands, clearing write or not
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_hit) |-> ((flags_q & $past(set_vec)) == $past(set_vec)));

   // R11: without a flag write, no flag bit is ever lost
   a_r11_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_flags) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/dual_irq_out.sv
module dual_irq_out #(
   parameter int NUM_SRC           = 32,
   parameter bit WAKE_NEEDS_MASTER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               master_q,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic [NUM_SRC-1:0] flags_q,
   output logic               irq,
   output logic               wake
);
   logic live;

   assign live = |(flags_q & mask_q);
   assign irq  = master_q && live;

   generate
      if (WAKE_NEEDS_MASTER) begin : g_wake_gated
         assign wake = master_q && live;
         // R8: a gated wake never fires with the master switch off
         a_r8_wake_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
            wake |-> master_q);
      end else begin : g_wake_free
         assign wake = live;
         // R9: an ungated wake is high whenever the master switch is off and a flag is live
         a_r9_wake_without_master: assert property (@(posedge clk) disable iff (!rst_n)
            (!master_q && (flags_q & mask_q) != '0) |-> wake);
      end
   endgenerate

   // R7: the interrupt line needs the master switch, and it implies wake
   a_r7_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (master_q && wake));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
   import dual_irq_pkg::*;
#(
   parameter int          NUM_CPUS     = 2,
   parameter int          NUM_SRC      = 32,
   parameter int          DATA_W       = 32,
   parameter int          ADDR_W       = 9,
   parameter int          BANK_LSB     = 8,
   parameter logic [1:0]  WAKE_GATED   = 2'b01,
   localparam int         CPU_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int         SRC_W        = $clog2(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                ev_valid,
   input  logic [CPU_W-1:0]    ev_cpu,
   input  logic [SRC_W-1:0]    ev_src,
   output logic [NUM_CPUS-1:0] irq,
   output logic [NUM_CPUS-1:0] wake
);
   generate
      if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie between 2 and DATA_W");
      end
      if (NUM_CPUS < 1 || NUM_CPUS > 2) begin : g_bad_cpus
         $error("NUM_CPUS must be 1 or 2");
      end
      if (BANK_LSB < 8 || BANK_LSB >= ADDR_W) begin : g_bad_map
         $error("BANK_LSB must be at least 8 and below ADDR_W");
      end
   endgenerate

   reg_sel_e           dec_sel;
   logic [CPU_W-1:0]   dec_cpu;
   logic               dec_hit;

   logic               master_q [NUM_CPUS];
   logic [NUM_SRC-1:0] mask_q   [NUM_CPUS];
   logic [NUM_SRC-1:0] flags_q  [NUM_CPUS];

   dual_irq_decode #(
      .ADDR_W   (ADDR_W),
      .BANK_LSB (BANK_LSB),
      .NUM_CPUS (NUM_CPUS),
      .CPU_W    (CPU_W)
   ) u_decode (
      .addr (reg_addr),
      .sel  (dec_sel),
      .cpu  (dec_cpu),
      .hit  (dec_hit)
   );

   generate
      for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
         logic wr_here;
         assign wr_here = reg_wr && dec_hit && (dec_cpu == CPU_W'(c));

         dual_irq_bank #(
            .NUM_SRC (NUM_SRC),
            .SRC_W   (SRC_W),
            .CPU_W   (CPU_W),
            .CPU_ID  (c)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_master (wr_here && dec_sel == SEL_MASTER),
            .wr_mask   (wr_here && dec_sel == SEL_MASK),
            .wr_flags  (wr_here && dec_sel == SEL_FLAGS),
            .wdata     (reg_wdata[NUM_SRC-1:0]),
            .ev_valid  (ev_valid),
            .ev_cpu    (ev_cpu),
            .ev_src    (ev_src),
            .master_q  (master_q[c]),
            .mask_q    (mask_q[c]),
            .flags_q   (flags_q[c])
         );

         dual_irq_out #(
            .NUM_SRC           (NUM_SRC),
            .WAKE_NEEDS_MASTER (WAKE_GATED[c])
         ) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .master_q (master_q[c]),
            .mask_q   (mask_q[c]),
            .flags_q  (flags_q[c]),
            .irq      (irq[c]),
            .wake     (wake[c])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (dec_hit) begin
         case (dec_sel)
            SEL_MASTER: reg_rdata = DATA_W'(master_q[dec_cpu]);
            SEL_MASK:   reg_rdata = DATA_W'(mask_q[dec_cpu]);
            SEL_FLAGS:  reg_rdata = DATA_W'(flags_q[dec_cpu]);
            default:    reg_rdata = '0;
         endcase
      end
   end

   // R6: master reads never show bits above bit 0
   a_r6_master_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && dec_sel == SEL_MASTER) |-> (reg_rdata[DATA_W-1:1] == '0));

   // R10: unmapped offsets read as zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (reg_rdata == '0));

endmodule

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_valid = 1'b0;
   logic [0:0]  ev_cpu = '0;
   logic [4:0]  ev_src = '0;
   logic [1:0]  irq;
   logic [1:0]  wake;

   int checks = 0;
   int errors = 0;

   logic        m_master [2];
   logic [31:0] m_mask   [2];
   logic [31:0] m_flags  [2];

   always #2 clk = ~clk;

   dual_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
      .ev_cpu(ev_cpu), .ev_src(ev_src), .irq(irq), .wake(wake)
   );

   localparam logic [7:0] O_MST = 8'h08;
   localparam logic [7:0] O_MSK = 8'h10;
   localparam logic [7:0] O_FLG = 8'h14;

   function automatic logic [8:0] adr(int c, logic [7:0] o);
      return {c[0], o};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model of a register write per R4, R6, R10
   task automatic model_wr(logic [8:0] a, logic [31:0] d);
      int c = int'(a[8]);
      case (a[7:0])
         O_MST:   m_master[c] = d[0];
         O_MSK:   m_mask[c]   = d;
         O_FLG:   m_flags[c]  = m_flags[c] & ~d;
         default: ;
      endcase
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd(string tag, logic [8:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   // event, optionally with a flag write in the same cycle (R5)
   task automatic pulse(int c, int s, bit with_wr, logic [31:0] clr);
      @(negedge clk);
      ev_valid = 1'b1; ev_cpu = c[0]; ev_src = s[4:0];
      if (with_wr) begin
         reg_wr = 1'b1; reg_addr = adr(c, O_FLG); reg_wdata = clr;
      end
      @(posedge clk); #1;
      ev_valid = 1'b0; reg_wr = 1'b0;
      if (with_wr) m_flags[c] = m_flags[c] & ~clr;
      m_flags[c] = m_flags[c] | ((32'd1 << s) & m_mask[c]);
   endtask

   // R7, R8, R9 expected outputs computed from the model
   task automatic chk_outs(string tag);
      for (int c = 0; c < 2; c++) begin
         logic live;
         live = (m_flags[c] & m_mask[c]) != 0;
         chk({tag, " R7 irq"}, {31'd0, irq[c]}, {31'd0, m_master[c] & live});
         if (c == 0) chk({tag, " R8 wake0"}, {31'd0, wake[0]}, {31'd0, m_master[0] & live});
         else        chk({tag, " R9 wake1"}, {31'd0, wake[1]}, {31'd0, live});
      end
   endtask

   task automatic chk_all_regs(string tag);
      for (int c = 0; c < 2; c++) begin
         rd({tag, " master"}, adr(c, O_MST), {31'd0, m_master[c]});
         rd({tag, " mask"},   adr(c, O_MSK), m_mask[c]);
         rd({tag, " flags"},  adr(c, O_FLG), m_flags[c]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin
         m_master[c] = 1'b0; m_mask[c] = '0; m_flags[c] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      chk_all_regs("R1 reset");
      chk("R1 irq", {30'd0, irq}, 32'd0);
      chk("R1 wake", {30'd0, wake}, 32'd0);

      // R2 R3: sweep every source on both processors, master off
      wr(adr(0, O_MSK), 32'h5555_5555);
      wr(adr(1, O_MSK), 32'hA5A5_0FF0);
      for (int c = 0; c < 2; c++) begin
         for (int s = 0; s < 32; s++) begin
            pulse(c, s, 1'b0, '0);
            rd("R2 R3 flags sweep", adr(c, O_FLG), m_flags[c]);
            rd("R2 other cpu untouched", adr(1 - c, O_FLG), m_flags[1 - c]);
            chk_outs("sweep");
         end
      end

      // R6: only master bit 0 is kept
      wr(adr(0, O_MST), 32'hFFFF_FFFF);
      rd("R6 master0 narrow", adr(0, O_MST), 32'd1);
      chk_outs("R7 master0 on");
      wr(adr(1, O_MST), 32'hFFFF_FFFE);
      rd("R6 master1 bit0 only", adr(1, O_MST), 32'd0);
      chk_outs("R9 master1 off");
      wr(adr(1, O_MST), 32'd1);
      chk_outs("R7 master1 on");

      // R4: clear selected bits only
      wr(adr(0, O_FLG), 32'h0000_FF00);
      rd("R4 partial clear", adr(0, O_FLG), m_flags[0]);
      wr(adr(0, O_FLG), 32'hFFFF_FFFF);
      rd("R4 full clear", adr(0, O_FLG), 32'd0);
      chk_outs("R4 after clear");

      // R11: mask change keeps flags but drops outputs
      wr(adr(1, O_MSK), 32'd0);
      rd("R11 flags kept", adr(1, O_FLG), m_flags[1]);
      chk_outs("R11 masked off");
      wr(adr(1, O_MSK), 32'hA5A5_0FF0);
      chk_outs("R11 mask restored");

      // R5: event and clear collide on one bit
      wr(adr(0, O_MSK), 32'hFFFF_FFFF);
      pulse(0, 0, 1'b0, '0);
      pulse(0, 7, 1'b1, 32'h0000_0081);
      rd("R5 set wins", adr(0, O_FLG), 32'h0000_0080);
      chk_outs("R5 outputs");

      // R10: map decode and bank isolation
      wr(adr(0, 8'h0C), 32'hDEAD_BEEF);
      rd("R10 unmapped read", adr(0, 8'h0C), 32'd0);
      wr(adr(1, O_MSK), 32'h1234_5678);
      rd("R10 bank isolation", adr(0, O_MSK), 32'hFFFF_FFFF);
      chk_all_regs("R10 all regs");
      chk_outs("R10 final");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule